// File: doc/BRIEF.md
# Ping-Pong Receive Acceptance Filter

This block sits behind a bus receiver that hands over each completed frame in one cycle: an 11-bit identifier, a remote-request flag, a length code and a payload. While the mode is switched on, two receive slots, A (index 0) and B (index 1), work as a double buffer. Only one slot is active at a time. An incoming frame is compared with the active slot's programmed filter identifier, under that slot's own mask. A frame that passes is written into the active slot, and the other slot becomes active. A frame that fails is dropped.

If both slots are programmed with the same identifier and mask, consecutive matching frames land in alternate slots. The host then has a whole frame time to empty one slot while the other fills. The host selects a slot, reads its stored frame from combinational read ports, and acknowledges it with a one-cycle pulse. The acknowledge clears the slot's full and overrun flags.

The control is a three-state machine. ST_OFF means the mode is disabled. ST_WAIT_A means slot A is active. ST_WAIT_B means slot B is active. Its transitions are:
- EN_ON: ST_OFF to ST_WAIT_A when `mode_en` is high.
- ACC_A: ST_WAIT_A to ST_WAIT_B when a frame is accepted into A.
- ACC_B: ST_WAIT_B to ST_WAIT_A when a frame is accepted into B.
- EN_OFF: either wait state to ST_OFF when `mode_en` is low.

Top module: `dualbuf_accept_filter`

## Requirements
- R1: After reset, `act_slot` is 0, both full flags and both overrun flags are 0, and every filter identifier, filter mask and stored field is zero. A zero mask accepts any identifier.
- R2: A frame is accepted when, for every bit i where the active slot's mask has a 1, bit i of the frame identifier equals bit i of that slot's filter identifier. Mask bits that are 0 are ignored.
- R3: An accepted frame is stored in the active slot at the clock edge that samples it, and `act_slot` toggles at that same edge. Accepted frames therefore fill A, B, A, B in strict order.
- R4: A rejected frame changes nothing: `act_slot`, the flags and the stored contents all hold.
- R5: Data frames (`frm_rtr`=0) and remote frames (`frm_rtr`=1) are accepted alike, and the flag is stored with the frame.
- R6: Storing a frame sets that slot's full flag. A `rd_ack` pulse clears the full and overrun flags of the slot chosen by `rd_sel`, one cycle later.
- R7: A frame accepted into a slot that is still full overwrites the slot and sets its overrun flag.
- R8: When a store and an acknowledge hit the same slot in the same cycle, the slot ends with the new frame, full set and overrun clear.
- R9: A frame is considered only in a cycle where `mode_en` is high and the machine was already enabled (not ST_OFF). Otherwise the frame is ignored. When the mode is off, `act_slot` reads 0, and every enable starts at slot A.
- R10: A configuration write (`cfg_we`, slot `cfg_sel`) takes effect for filtering from the next cycle. A frame in the same cycle is filtered against the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Enables ping-pong reception |
| cfg_we | input | 1 | Filter write strobe |
| cfg_sel | input | 1 | Slot written (0=A, 1=B) |
| cfg_id | input | 11 | Filter identifier to write |
| cfg_mask | input | 11 | Filter mask to write (1 = compare) |
| frm_valid | input | 1 | Completed frame present this cycle |
| frm_id | input | 11 | Frame identifier |
| frm_rtr | input | 1 | 1 = remote frame, 0 = data frame |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload |
| rd_sel | input | 1 | Slot shown on read ports |
| rd_ack | input | 1 | Acknowledge (pop) of slot `rd_sel` |
| rd_id | output | 11 | Stored identifier of selected slot |
| rd_rtr | output | 1 | Stored remote flag of selected slot |
| rd_dlc | output | 4 | Stored length code of selected slot |
| rd_data | output | 64 | Stored payload of selected slot |
| slot_full | output | 2 | Full flags, bit 0 = A, bit 1 = B |
| slot_ovr | output | 2 | Overrun flags, bit 0 = A, bit 1 = B |
| act_slot | output | 1 | Active slot (0=A, 1=B) |

## Verification
Two collisions can fall in the same cycle. The first is a store and a host acknowledge aimed at the same slot. The second is a filter rewrite and a frame that is judged by the old setting. Directed steps provoke each one on purpose: an acknowledge of the slot that is about to receive a matching frame, and a filter write issued in the same cycle as a frame. Random traffic then keeps producing both collisions. Every cycle, a bench model applies the requirement rules (acknowledge and store resolved as in R8, the old filter used as in R10). It compares flags, the active slot and the stored contents at the falling edge after the deciding rising edge.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT_A = 2'd1,
        ST_WAIT_B = 2'd2
    } ctrl_state_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/dbf_match.sv
module dbf_match #(
    parameter int ID_W = 11
) (
    input  logic [ID_W-1:0] frame_id,
    input  logic [ID_W-1:0] ref_id,
    input  logic [ID_W-1:0] ref_mask,
    output logic            hit
);
    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (frame_id ^ ref_id) & ref_mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
    import dbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic frm_valid,
    input  logic hit,
    output logic act,
    output logic store_a,
    output logic store_b
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (mode_en) state_d = ST_WAIT_A;
            ST_WAIT_A: if (!mode_en) state_d = ST_OFF;
                       else if (frm_valid && hit) state_d = ST_WAIT_B;
            ST_WAIT_B: if (!mode_en) state_d = ST_OFF;
                       else if (frm_valid && hit) state_d = ST_WAIT_A;
            default:   state_d = ST_OFF;
        endcase
    end

    always_comb begin
        act     = 1'b0;
        store_a = 1'b0;
        store_b = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_WAIT_A: store_a = mode_en && frm_valid && hit;
            ST_WAIT_B: begin
                act     = 1'b1;
                store_b = mode_en && frm_valid && hit;
            end
            default: ;
        endcase
    end

    // R3: an accepted frame moves the pointer to the other slot
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && mode_en && frm_valid && hit) |=> (act != $past(act)));

    // R4: a rejected frame leaves the pointer where it was
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && mode_en && frm_valid && !hit) |=> $stable(state_q));

    // R9: enabling always starts at slot A
    assert_start_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && mode_en) |=> (state_q == ST_WAIT_A));

    // R9: disabled mode reports slot A
    assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (state_q == ST_OFF && !act));
endmodule

// File: rtl/dbf_slot.sv
module dbf_slot #(
    parameter int ID_W   = 11,
    parameter int DLC_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ID_W-1:0]   cfg_mask,
    input  logic              wr,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_rtr,
    input  logic [DLC_W-1:0]  wr_dlc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    output logic [ID_W-1:0]   flt_id,
    output logic [ID_W-1:0]   flt_mask,
    output logic [ID_W-1:0]   st_id,
    output logic              st_rtr,
    output logic [DLC_W-1:0]  st_dlc,
    output logic [DATA_W-1:0] st_data,
    output logic              full,
    output logic              ovr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_id   <= '0;
            flt_mask <= '0;
        end else if (cfg_we) begin
            flt_id   <= cfg_id;
            flt_mask <= cfg_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_id   <= '0;
            st_rtr  <= 1'b0;
            st_dlc  <= '0;
            st_data <= '0;
        end else if (wr) begin
            st_id   <= wr_id;
            st_rtr  <= wr_rtr;
            st_dlc  <= wr_dlc;
            st_data <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (wr)       full <= 1'b1;
            else if (ack) full <= 1'b0;
            if (ack)             ovr <= 1'b0;
            else if (wr && full) ovr <= 1'b1;
        end
    end

    // R6: a store leaves the slot full
    assert_full_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full);

    // R7: a store into a full, unacknowledged slot flags overrun
    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !ack) |=> ovr);

    // R8: acknowledge together with a store keeps full, clears overrun
    assert_ack_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ack) |=> (full && !ovr));

    // R6: acknowledge alone empties the slot
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr) |=> (!full && !ovr));
endmodule

// File: rtl/dualbuf_accept_filter.sv
module dualbuf_accept_filter
    import dbf_pkg::*;
#(
    parameter int ID_W   = 11,
    parameter int DLC_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ID_W-1:0]   cfg_mask,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_rtr,
    input  logic [DLC_W-1:0]  frm_dlc,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              rd_sel,
    input  logic              rd_ack,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_rtr,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        slot_full,
    output logic [1:0]        slot_ovr,
    output logic              act_slot
);
    logic [ID_W-1:0]   flt_id   [NUM_SLOTS];
    logic [ID_W-1:0]   flt_mask [NUM_SLOTS];
    logic [ID_W-1:0]   st_id    [NUM_SLOTS];
    logic              st_rtr   [NUM_SLOTS];
    logic [DLC_W-1:0]  st_dlc   [NUM_SLOTS];
    logic [DATA_W-1:0] st_data  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] wr_vec;
    logic act, hit, store_a, store_b;

    dbf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (mode_en),
        .frm_valid(frm_valid),
        .hit      (hit),
        .act      (act),
        .store_a  (store_a),
        .store_b  (store_b)
    );

    dbf_match #(.ID_W(ID_W)) u_match (
        .frame_id(frm_id),
        .ref_id  (flt_id[act]),
        .ref_mask(flt_mask[act]),
        .hit     (hit)
    );

    assign wr_vec = {store_b, store_a};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dbf_slot #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we && (cfg_sel == s[0])),
            .cfg_id  (cfg_id),
            .cfg_mask(cfg_mask),
            .wr      (wr_vec[s]),
            .wr_id   (frm_id),
            .wr_rtr  (frm_rtr),
            .wr_dlc  (frm_dlc),
            .wr_data (frm_data),
            .ack     (rd_ack && (rd_sel == s[0])),
            .flt_id  (flt_id[s]),
            .flt_mask(flt_mask[s]),
            .st_id   (st_id[s]),
            .st_rtr  (st_rtr[s]),
            .st_dlc  (st_dlc[s]),
            .st_data (st_data[s]),
            .full    (slot_full[s]),
            .ovr     (slot_ovr[s])
        );
    end

    assign rd_id    = st_id[rd_sel];
    assign rd_rtr   = st_rtr[rd_sel];
    assign rd_dlc   = st_dlc[rd_sel];
    assign rd_data  = st_data[rd_sel];
    assign act_slot = act;

    // R3: at most one slot is written per cycle, and only the active one
    assert_single_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec) && (wr_vec[1] -> act) && (wr_vec[0] -> !act));

    // R2: a stored frame agrees with the active filter on every masked bit
    assert_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_vec) |-> (((frm_id ^ flt_id[act]) & flt_mask[act]) == '0));
endmodule

// File: tb/dualbuf_accept_filter_bench.sv
`timescale 1ns/1ps
module dualbuf_accept_filter_bench;
    localparam int ID_W = 11, DLC_W = 4, DATA_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [ID_W-1:0] cfg_id = '0, cfg_mask = '0, frm_id = '0;
    logic frm_valid = 1'b0, frm_rtr = 1'b0, rd_sel = 1'b0, rd_ack = 1'b0;
    logic [DLC_W-1:0] frm_dlc = '0;
    logic [DATA_W-1:0] frm_data = '0;
    logic [ID_W-1:0] rd_id;
    logic rd_rtr, act_slot;
    logic [DLC_W-1:0] rd_dlc;
    logic [DATA_W-1:0] rd_data;
    logic [1:0] slot_full, slot_ovr;

    always #2.5 clk = ~clk;

    dualbuf_accept_filter u_dualbuf_accept_filter (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_id(cfg_id), .cfg_mask(cfg_mask), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data), .rd_sel(rd_sel),
        .rd_ack(rd_ack), .rd_id(rd_id), .rd_rtr(rd_rtr), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .slot_full(slot_full), .slot_ovr(slot_ovr), .act_slot(act_slot)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference model
    logic m_on = 1'b0, m_ptr = 1'b0;
    logic [ID_W-1:0] m_fid [2], m_fmask [2], m_sid [2];
    logic m_srtr [2];
    logic [DLC_W-1:0] m_sdlc [2];
    logic [DATA_W-1:0] m_sdata [2];
    logic [1:0] m_full = '0, m_ovr = '0;

    function automatic logic ref_hit(logic [ID_W-1:0] id, logic [ID_W-1:0] rid, logic [ID_W-1:0] rmask);
        return ((id ^ rid) & rmask) == '0;
    endfunction

    task automatic model_reset();
        m_on = 0; m_ptr = 0; m_full = 0; m_ovr = 0;
        for (int s = 0; s < 2; s++) begin
            m_fid[s] = '0; m_fmask[s] = '0; m_sid[s] = '0;
            m_srtr[s] = 0; m_sdlc[s] = '0; m_sdata[s] = '0;
        end
    endtask

    task automatic model_update();
        logic acc;
        int p;
        p = int'(m_ptr);
        acc = m_on && mode_en && frm_valid && ref_hit(frm_id, m_fid[p], m_fmask[p]);
        for (int s = 0; s < 2; s++) begin
            logic ak, wr;
            ak = rd_ack && (int'(rd_sel) == s);
            wr = acc && (p == s);
            if (ak) m_ovr[s] = 1'b0;
            else if (wr && m_full[s]) m_ovr[s] = 1'b1;
            if (wr) m_full[s] = 1'b1;
            else if (ak) m_full[s] = 1'b0;
            if (wr) begin
                m_sid[s] = frm_id; m_srtr[s] = frm_rtr;
                m_sdlc[s] = frm_dlc; m_sdata[s] = frm_data;
            end
        end
        if (acc) m_ptr = ~m_ptr;
        if (!(m_on && mode_en)) m_ptr = 1'b0;
        m_on = mode_en;
        if (cfg_we) begin
            m_fid[int'(cfg_sel)] = cfg_id;
            m_fmask[int'(cfg_sel)] = cfg_mask;
        end
    endtask

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        int r;
        r = int'(rd_sel);
        chk(tag, "act_slot", 64'(act_slot), 64'(m_ptr));
        chk(tag, "slot_full", 64'(slot_full), 64'(m_full));
        chk(tag, "slot_ovr", 64'(slot_ovr), 64'(m_ovr));
        chk(tag, "rd_id", 64'(rd_id), 64'(m_sid[r]));
        chk(tag, "rd_rtr", 64'(rd_rtr), 64'(m_srtr[r]));
        chk(tag, "rd_dlc", 64'(rd_dlc), 64'(m_sdlc[r]));
        chk(tag, "rd_data", rd_data, m_sdata[r]);
    endtask

    task automatic step(string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        cfg_we = 0; frm_valid = 0; rd_ack = 0;
    endtask

    task automatic cfg(logic sel, logic [ID_W-1:0] id, logic [ID_W-1:0] mask);
        cfg_we = 1; cfg_sel = sel; cfg_id = id; cfg_mask = mask;
    endtask

    task automatic frame(logic [ID_W-1:0] id, logic rtr);
        frm_valid = 1; frm_id = id; frm_rtr = rtr;
        frm_dlc = DLC_W'($urandom); frm_data = {$urandom, $urandom};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1");
        chk("R1", "full after reset", 64'(slot_full), 64'd0);

        // R1 zero mask accepts anything; R9 frame in the enabling cycle is ignored
        mode_en = 1; frame(11'h3A5, 0); step("R9");
        chk("R9", "full on enable cycle", 64'(slot_full), 64'd0);

        // R10: config write together with frame; old (zero) mask accepts
        cfg(0, 11'h123, 11'h7FF); frame(11'h000, 0); step("R10");
        chk("R10", "act after old-filter accept", 64'(act_slot), 64'd1);
        cfg(1, 11'h123, 11'h7FF); rd_ack = 1; rd_sel = 0; step("R6");
        chk("R6", "full after ack", 64'(slot_full), 64'd0);

        // R3 alternation with identical filters
        frame(11'h123, 0); step("R3");
        chk("R3", "full after B store", 64'(slot_full), 64'd2);
        chk("R3", "act back to A", 64'(act_slot), 64'd0);
        frame(11'h123, 0); step("R3");
        // R4 mismatch
        frame(11'h124, 0); step("R4");
        chk("R4", "act held", 64'(act_slot), 64'd1);
        // R5 remote frame into B (full -> R7 overrun)
        rd_sel = 1; frame(11'h123, 1); step("R5");
        chk("R5", "remote stored", 64'(rd_rtr), 64'd1);
        chk("R7", "overrun B", 64'(slot_ovr), 64'd2);
        // R8 ack of A with store into A
        rd_sel = 0; rd_ack = 1; frame(11'h123, 0); step("R8");
        chk("R8", "full kept", 64'(slot_full), 64'd3);
        chk("R8", "ovr A clear", 64'(slot_ovr[0]), 64'd0);

        // R2 partial mask: B active now
        cfg(1, 11'h500, 11'h700); step("R10");
        frame(11'h5FF, 0); step("R2");
        chk("R2", "partial mask accept", 64'(act_slot), 64'd0);
        cfg(0, 11'h500, 11'h700); step("R10");
        frame(11'h4FF, 0); step("R2");
        chk("R2", "masked bit differs reject", 64'(act_slot), 64'd0);

        // R9 off: frames ignored, pointer resets
        frame(11'h500, 0); step("R2");
        mode_en = 0; frame(11'h500, 0); step("R9");
        frame(11'h500, 0); step("R9");
        chk("R9", "act when off", 64'(act_slot), 64'd0);
        mode_en = 1; step("R9");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = int'($urandom_range(0, 99));
            mode_en = (k < 3) ? 1'b0 : 1'b1;
            if ($urandom_range(0, 9) == 0) begin
                logic [ID_W-1:0] mk;
                case ($urandom_range(0, 3))
                    0: mk = '1;
                    1: mk = '0;
                    2: mk = ID_W'(1) << $urandom_range(0, ID_W-1);
                    default: mk = ID_W'($urandom);
                endcase
                cfg(1'($urandom), ID_W'($urandom), mk);
            end
            if ($urandom_range(0, 2) != 0) begin
                logic [ID_W-1:0] id;
                int p;
                p = int'(m_ptr);
                if ($urandom_range(0, 3) != 0) id = m_fid[p] ^ (ID_W'($urandom) & ~m_fmask[p]);
                else id = ID_W'($urandom);
                frame(id, 1'($urandom));
            end
            rd_sel = 1'($urandom);
            rd_ack = ($urandom_range(0, 3) == 0);
            step("R3");
        end
        finish_run();
    end
endmodule